// File: doc/BRIEF.md
# Four-Channel DMA Transfer Engine

The block moves data between memory and peripherals without processor involvement. Four channels each hold a source address, a destination address, a 24-bit transfer count and a configuration word. When a channel is enabled and its peripheral request line is high, the engine arbitrates for it. It then issues bus requests on a single-master interface: address, write strobe, transfer size, and a ready handshake from the bus. Data itself travels on the system bus and not through this block. The engine generates the addresses, counts the transfers and signals completion.

A channel works in one of two address modes. In single-address mode the peripheral is selected by its acknowledge strobe, and one bus cycle per transfer addresses the memory side. In dual-address mode each transfer is a read at the source address followed by a write at the destination address. A channel also works in one of two bus modes. In cycle-steal mode the bus is released after every transfer. In burst mode the channel keeps the bus until its count runs out. Arbitration uses either fixed priority or round robin, selected by an input pin. Channels are programmed through a simple write port, one register per write.

Top module: `dma4_engine`

## Requirements
- R1: After reset, busReq, dack, irq and xferEnd are all zero, and no channel is enabled.
- R2: A dual-address transfer consists of a read bus cycle (busWrite=0) at the source address, followed by a write bus cycle (busWrite=1) at the destination address. dack stays zero during both cycles.
- R3: A single-address transfer (config bit 8 set) consists of exactly one bus cycle, during which dack bit c of the active channel c is high. With config bit 9 clear, the memory side is read at the source address. With config bit 9 set, the memory side is written at the destination address.
- R4: After each transfer, the source address and the destination address each step by their own 2-bit mode: 0 holds the address, 1 adds the size in bytes, 2 subtracts the size in bytes. Source mode is config bits 5:4 and destination mode is config bits 7:6.
- R5: The count register (select 2) gives the number of transfers, and it decrements once per transfer. A channel completes after the transfer that is made with the count equal to 1. A count of 0 stands for 2^24 transfers, so such a channel does not complete within a short run.
- R6: When a channel completes, its enable (config bit 0) clears and its xferEnd bit sets. The irq bit is xferEnd ANDed with the interrupt enable (config bit 11). Writing select 4 with data bit 0 set clears the channel's xferEnd.
- R7: With arbRoundRobin=0, the lowest-numbered pending channel wins each arbitration. A channel is pending when its dreq bit and its enable are both high.
- R8: With arbRoundRobin=1, the search starts at the channel after the one granted last. After reset, the last-granted channel counts as channel 3.
- R9: In cycle-steal mode (config bit 10 clear), the engine returns to arbitration after every transfer. In burst mode, the granted channel keeps the bus for back-to-back transfers until it completes, whatever other channels request.
- R10: While busReq is high and busReady is low, busReq, busAddr, busWrite and busSize hold their values, and no transfer advances.
- R11: The size code is config bits 3:1: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes, 3 is 8 bytes, 4 is a 32-byte block. busSize presents the active channel's code. The register selects are: 0 source, 1 destination, 2 count, 3 config, 4 flag clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regChan | input | 2 | Channel addressed by the write |
| regSel | input | 3 | Register select within the channel |
| regWdata | input | 32 | Write data |
| arbRoundRobin | input | 1 | 1 selects round-robin arbitration, 0 selects fixed priority |
| dreq | input | 4 | Per-channel transfer request |
| busReady | input | 1 | Bus accepts the current cycle |
| busReq | output | 1 | Bus cycle requested |
| busWrite | output | 1 | 1 for a write cycle, 0 for a read cycle |
| busAddr | output | 32 | Bus cycle address |
| busSize | output | 3 | Size code of the bus cycle |
| dack | output | 4 | Per-channel peripheral acknowledge, single-address only |
| irq | output | 4 | Per-channel completion interrupt |
| xferEnd | output | 4 | Per-channel sticky completion flag |

## Verification
The bench runs the following corner cases.

- **Burst hold.** A burst channel keeps the bus after a higher-priority channel becomes enabled in the middle of the run. An engine that re-arbitrated between beats would let channel 0 break into the burst.
- **Round-robin order.** Two channels request together, and the grant must alternate between them. A pointer that failed to advance would starve the second channel under round robin.
- **Fixed-priority order.** With the same two requests, the grant must not alternate under fixed priority.
- **Count of zero.** The channel must keep running rather than complete at once or after a single transfer.
- **Address stepping.** The 32-byte and 8-byte step sizes are checked, together with the hold and decrement modes.
- **Stalled bus.** A stall must freeze the address and the direction.
- **Masked interrupt.** With the interrupt enable clear, the flag must set but irq must stay low.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam int NUM_CH = 4;
  localparam int CH_W = $clog2(NUM_CH);

  typedef enum logic [1:0] {STEP_FIX = 2'd0, STEP_INC = 2'd1, STEP_DEC = 2'd2, STEP_RSV = 2'd3} stepMode_t;
  typedef enum logic [1:0] {PH_IDLE, PH_READ, PH_WRITE, PH_SINGLE} phase_t;

  // Configuration word, bit 0 upward: enable, size[3:1], srcStep[5:4],
  // dstStep[7:6], singleAddr[8], devToMem[9], burst[10], irqEn[11]
  typedef struct packed {
    logic      irqEn;
    logic      burst;
    logic      devToMem;
    logic      singleAddr;
    stepMode_t dstStep;
    stepMode_t srcStep;
    logic [2:0] size;
    logic      enable;
  } chanCfg_t;

  localparam int CFG_W = $bits(chanCfg_t);

  localparam logic [2:0] SEL_SRC = 3'd0;
  localparam logic [2:0] SEL_DST = 3'd1;
  localparam logic [2:0] SEL_CNT = 3'd2;
  localparam logic [2:0] SEL_CFG = 3'd3;
  localparam logic [2:0] SEL_CLR = 3'd4;

  // Strobes from control to datapath
  typedef struct packed {
    logic            stepXfer;
    logic [CH_W-1:0] chan;
    phase_t          phase;
  } ctrlStrobe_t;
endpackage

// File: rtl/dma_datapath.sv
module dma_datapath
  import dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 24
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    regWe,
  input  logic [CH_W-1:0]         regChan,
  input  logic [2:0]              regSel,
  input  logic [ADDR_W-1:0]       regWdata,
  input  ctrlStrobe_t             strobe,
  output chanCfg_t [NUM_CH-1:0]   cfgVec,
  output logic [NUM_CH-1:0]       lastXfer,
  output logic [NUM_CH-1:0]       xferEnd,
  output logic [NUM_CH-1:0]       irq,
  output logic [ADDR_W-1:0]       busAddr
);
  logic [ADDR_W-1:0] srcArr [NUM_CH];
  logic [ADDR_W-1:0] dstArr [NUM_CH];

  function automatic logic [ADDR_W-1:0] nextAddr(input logic [ADDR_W-1:0] a,
                                                 input stepMode_t m,
                                                 input logic [2:0] sz);
    logic [ADDR_W-1:0] delta;
    delta = (sz >= 3'd4) ? ADDR_W'(32) : (ADDR_W'(1) << sz);
    case (m)
      STEP_INC: return a + delta;
      STEP_DEC: return a - delta;
      default:  return a;
    endcase
  endfunction

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [ADDR_W-1:0] srcR, dstR;
    logic [CNT_W-1:0]  cntR;
    chanCfg_t          cfgR;
    logic              endR;
    logic              hit, stepHere, finishHere;

    assign hit        = regWe && (regChan == CH_W'(c));
    assign stepHere   = strobe.stepXfer && (strobe.chan == CH_W'(c));
    assign finishHere = stepHere && (cntR == CNT_W'(1));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        srcR <= '0;
        dstR <= '0;
        cntR <= '0;
        cfgR <= '0;
        endR <= 1'b0;
      end else begin
        if (hit && regSel == SEL_SRC) srcR <= regWdata;
        else if (stepHere)            srcR <= nextAddr(srcR, cfgR.srcStep, cfgR.size);
        if (hit && regSel == SEL_DST) dstR <= regWdata;
        else if (stepHere)            dstR <= nextAddr(dstR, cfgR.dstStep, cfgR.size);
        if (hit && regSel == SEL_CNT) cntR <= regWdata[CNT_W-1:0];
        else if (stepHere)            cntR <= cntR - CNT_W'(1);
        if (hit && regSel == SEL_CFG) cfgR <= chanCfg_t'(regWdata[CFG_W-1:0]);
        if (finishHere)               cfgR.enable <= 1'b0;
        if (finishHere)               endR <= 1'b1;
        else if (hit && regSel == SEL_CLR && regWdata[0]) endR <= 1'b0;
      end
    end

    assign srcArr[c]   = srcR;
    assign dstArr[c]   = dstR;
    assign cfgVec[c]   = cfgR;
    assign lastXfer[c] = (cntR == CNT_W'(1));
    assign xferEnd[c]  = endR;
    assign irq[c]      = endR & cfgR.irqEn;
  end

  always_comb begin
    case (strobe.phase)
      PH_READ:   busAddr = srcArr[strobe.chan];
      PH_WRITE:  busAddr = dstArr[strobe.chan];
      PH_SINGLE: busAddr = cfgVec[strobe.chan].devToMem ? dstArr[strobe.chan] : srcArr[strobe.chan];
      default:   busAddr = '0;
    endcase
  end
endmodule

// File: rtl/dma_control.sv
module dma_control
  import dma_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_CH-1:0]     dreq,
  input  logic                  arbRoundRobin,
  input  chanCfg_t [NUM_CH-1:0] cfgVec,
  input  logic [NUM_CH-1:0]     lastXfer,
  input  logic                  busReady,
  output ctrlStrobe_t           strobe,
  output logic                  busReq,
  output logic                  busWrite,
  output logic [2:0]            busSize,
  output logic [NUM_CH-1:0]     dack
);
  phase_t          phase;
  logic [CH_W-1:0] activeCh, lastGrant, grantCh;
  logic [NUM_CH-1:0] pending;
  logic            found, xferDone;
  chanCfg_t        actCfg;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_pend
    assign pending[c] = dreq[c] & cfgVec[c].enable;
  end

  always_comb begin
    grantCh = '0;
    found   = 1'b0;
    for (int k = 0; k < NUM_CH; k++) begin
      int idx;
      idx = arbRoundRobin ? ((int'(lastGrant) + 1 + k) % NUM_CH) : k;
      if (!found && pending[idx]) begin
        grantCh = CH_W'(idx);
        found   = 1'b1;
      end
    end
  end

  assign actCfg   = cfgVec[activeCh];
  assign xferDone = busReady && (phase == PH_WRITE || phase == PH_SINGLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase     <= PH_IDLE;
      activeCh  <= '0;
      lastGrant <= CH_W'(NUM_CH - 1);
    end else begin
      case (phase)
        PH_IDLE:
          if (found) begin
            activeCh  <= grantCh;
            lastGrant <= grantCh;
            phase     <= cfgVec[grantCh].singleAddr ? PH_SINGLE : PH_READ;
          end
        PH_READ:
          if (busReady) phase <= PH_WRITE;
        default:
          if (busReady) begin
            if (actCfg.burst && !lastXfer[activeCh])
              phase <= actCfg.singleAddr ? PH_SINGLE : PH_READ;
            else
              phase <= PH_IDLE;
          end
      endcase
    end
  end

  assign strobe.stepXfer = xferDone;
  assign strobe.chan     = activeCh;
  assign strobe.phase    = phase;

  assign busReq   = (phase != PH_IDLE);
  assign busWrite = (phase == PH_WRITE) || (phase == PH_SINGLE && actCfg.devToMem);
  assign busSize  = actCfg.size;
  assign dack     = (phase == PH_SINGLE) ? (NUM_CH'(1) << activeCh) : '0;
endmodule

// File: rtl/dma4_engine.sv
module dma4_engine
  import dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [CH_W-1:0]   regChan,
  input  logic [2:0]        regSel,
  input  logic [ADDR_W-1:0] regWdata,
  input  logic              arbRoundRobin,
  input  logic [NUM_CH-1:0] dreq,
  input  logic              busReady,
  output logic              busReq,
  output logic              busWrite,
  output logic [ADDR_W-1:0] busAddr,
  output logic [2:0]        busSize,
  output logic [NUM_CH-1:0] dack,
  output logic [NUM_CH-1:0] irq,
  output logic [NUM_CH-1:0] xferEnd
);
  ctrlStrobe_t           strobe;
  chanCfg_t [NUM_CH-1:0] cfgVec;
  logic [NUM_CH-1:0]     lastXfer;

  dma_datapath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regChan(regChan), .regSel(regSel),
    .regWdata(regWdata), .strobe(strobe), .cfgVec(cfgVec), .lastXfer(lastXfer),
    .xferEnd(xferEnd), .irq(irq), .busAddr(busAddr)
  );

  dma_control u_ctl (
    .clk(clk), .rstN(rstN), .dreq(dreq), .arbRoundRobin(arbRoundRobin),
    .cfgVec(cfgVec), .lastXfer(lastXfer), .busReady(busReady), .strobe(strobe),
    .busReq(busReq), .busWrite(busWrite), .busSize(busSize), .dack(dack)
  );
endmodule

// File: rtl/dma4_engine_chk.sv
module dma4_engine_chk #(
  parameter int ADDR_W = 32,
  parameter int NCH    = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              busReady,
  input logic              busReq,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [2:0]        busSize,
  input logic [NCH-1:0]    dack,
  input logic [NCH-1:0]    irq,
  input logic [NCH-1:0]    xferEnd
);
  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busReady |=> busReq && $stable(busAddr) && $stable(busWrite) && $stable(busSize));

  assert_dack_onehot_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(dack));

  assert_dack_with_bus_R3: assert property (@(posedge clk) disable iff (!rstN)
    (dack != '0) |-> busReq);

  assert_read_then_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    busReq && busReady && !busWrite && dack == '0 |=> busReq && busWrite);

  assert_irq_needs_flag_R6: assert property (@(posedge clk) disable iff (!rstN)
    (irq & ~xferEnd) == '0);
endmodule

bind dma4_engine dma4_engine_chk #(.ADDR_W(ADDR_W), .NCH(dma_pkg::NUM_CH)) u_chk (
  .clk(clk), .rstN(rstN), .busReady(busReady), .busReq(busReq), .busWrite(busWrite),
  .busAddr(busAddr), .busSize(busSize), .dack(dack), .irq(irq), .xferEnd(xferEnd)
);

// File: tb/dma4_engine_tb.sv
module dma4_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MAXLOG = 64;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [1:0]  regChan = '0;
  logic [2:0]  regSel = '0;
  logic [31:0] regWdata = '0;
  logic        arbRoundRobin = 1'b0;
  logic [3:0]  dreq = '0;
  logic        busReady = 1'b1;
  logic        busReq, busWrite;
  logic [31:0] busAddr;
  logic [2:0]  busSize;
  logic [3:0]  dack, irq, xferEnd;

  int nChecks = 0;
  int nFails = 0;
  int cycles = 0;

  logic [31:0] logAddr [MAXLOG];
  logic        logWr   [MAXLOG];
  logic [3:0]  logDack [MAXLOG];
  logic [2:0]  logSize [MAXLOG];
  int nLog = 0;

  dma4_engine u_dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regChan(regChan), .regSel(regSel),
    .regWdata(regWdata), .arbRoundRobin(arbRoundRobin), .dreq(dreq), .busReady(busReady),
    .busReq(busReq), .busWrite(busWrite), .busAddr(busAddr), .busSize(busSize),
    .dack(dack), .irq(irq), .xferEnd(xferEnd)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // Accepted bus cycles, sampled mid-cycle
  always @(negedge clk) begin
    if (rstN && busReq && busReady && nLog < MAXLOG) begin
      logAddr[nLog] = busAddr;
      logWr[nLog]   = busWrite;
      logDack[nLog] = dack;
      logSize[nLog] = busSize;
      nLog++;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      nFails++;
      $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 100000)", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  function automatic logic [31:0] cfgWord(bit en, int sz, int sMode, int dMode,
                                          bit single, bit d2m, bit burst, bit ie);
    logic [2:0] s3 = sz[2:0];
    logic [1:0] sm = sMode[1:0];
    logic [1:0] dm = dMode[1:0];
    return {20'b0, ie, burst, d2m, single, dm, sm, s3, en};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic checkLog(string req, int i, logic [31:0] a, logic w, logic [3:0] d);
    check(req, logAddr[i], a);
    check(req, {31'b0, logWr[i]}, {31'b0, w});
    check(req, {28'b0, logDack[i]}, {28'b0, d});
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; dreq = '0; regWe = 1'b0; arbRoundRobin = 1'b0; busReady = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    nLog = 0;
  endtask

  task automatic wr(int ch, logic [2:0] sel, logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regChan = ch[1:0]; regSel = sel; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic prog(int ch, logic [31:0] s, logic [31:0] d, logic [31:0] n, logic [31:0] cfg);
    wr(ch, 3'd0, s);
    wr(ch, 3'd1, d);
    wr(ch, 3'd2, n);
    wr(ch, 3'd3, cfg);
  endtask

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic testReset();
    doReset();
    check("R1 busReq", {31'b0, busReq}, 32'd0);
    check("R1 dack", {28'b0, dack}, 32'd0);
    check("R1 irq", {28'b0, irq}, 32'd0);
    check("R1 xferEnd", {28'b0, xferEnd}, 32'd0);
    dreq = 4'hF;
    waitCyc(5);
    check("R1 no channel enabled", {31'b0, busReq}, 32'd0);
  endtask

  task automatic testDual();
    doReset();
    prog(0, 32'h1000, 32'h2000, 32'd3, cfgWord(1, 2, 1, 1, 0, 0, 0, 1));
    dreq = 4'b0001;
    waitCyc(20);
    check("R5 dual count 3", nLog, 6);
    for (int i = 0; i < 3; i++) begin
      checkLog("R2 read src", 2 * i, 32'h1000 + 4 * i, 1'b0, 4'b0);
      checkLog("R2 write dst", 2 * i + 1, 32'h2000 + 4 * i, 1'b1, 4'b0);
    end
    check("R11 size 32-bit", {29'b0, logSize[0]}, 32'd2);
    check("R6 xferEnd", {28'b0, xferEnd}, 32'h1);
    check("R6 irq", {28'b0, irq}, 32'h1);
    check("R6 bus idle after end", {31'b0, busReq}, 32'd0);
  endtask

  task automatic testSteps();
    doReset();
    prog(2, 32'h100, 32'h800, 32'd2, cfgWord(1, 4, 1, 2, 0, 0, 0, 0));
    dreq = 4'b0100;
    waitCyc(15);
    check("R4 count", nLog, 4);
    checkLog("R4 blk src0", 0, 32'h100, 1'b0, 4'b0);
    checkLog("R4 blk dst0", 1, 32'h800, 1'b1, 4'b0);
    checkLog("R4 blk src inc 32", 2, 32'h120, 1'b0, 4'b0);
    checkLog("R4 blk dst dec 32", 3, 32'h7E0, 1'b1, 4'b0);
    check("R11 size block", {29'b0, logSize[0]}, 32'd4);
    doReset();
    prog(1, 32'h40, 32'h300, 32'd2, cfgWord(1, 3, 0, 1, 0, 0, 0, 0));
    dreq = 4'b0010;
    waitCyc(15);
    checkLog("R4 src fixed", 2, 32'h40, 1'b0, 4'b0);
    checkLog("R4 dst inc 8", 3, 32'h308, 1'b1, 4'b0);
    check("R11 size 64-bit", {29'b0, logSize[1]}, 32'd3);
  endtask

  task automatic testSingle();
    doReset();
    prog(1, 32'hAAA0, 32'h5000, 32'd2, cfgWord(1, 1, 1, 2, 1, 1, 0, 0));
    dreq = 4'b0010;
    waitCyc(15);
    check("R3 one cycle per transfer (dev->mem)", nLog, 2);
    checkLog("R3 write dst with dack", 0, 32'h5000, 1'b1, 4'b0010);
    checkLog("R3 R4 dst dec 2", 1, 32'h4FFE, 1'b1, 4'b0010);
    doReset();
    prog(1, 32'hAAA0, 32'h5000, 32'd2, cfgWord(1, 1, 1, 0, 1, 0, 0, 0));
    dreq = 4'b0010;
    waitCyc(15);
    check("R3 one cycle per transfer (mem->dev)", nLog, 2);
    checkLog("R3 read src with dack", 0, 32'hAAA0, 1'b0, 4'b0010);
    checkLog("R3 R4 src inc 2", 1, 32'hAAA2, 1'b0, 4'b0010);
  endtask

  task automatic testCompletion();
    doReset();
    prog(3, 32'h10, 32'h20, 32'd1, cfgWord(1, 0, 1, 1, 0, 0, 0, 0));
    dreq = 4'b1000;
    waitCyc(10);
    check("R6 flag set with irq masked", {28'b0, xferEnd}, 32'h8);
    check("R6 irq masked", {28'b0, irq}, 32'h0);
    waitCyc(10);
    check("R6 enable cleared, no further transfer", nLog, 2);
    wr(3, 3'd4, 32'h1);
    check("R6 flag cleared by write", {28'b0, xferEnd}, 32'h0);
    doReset();
    prog(2, 32'h10, 32'h20, 32'd1, cfgWord(1, 0, 1, 1, 0, 0, 0, 1));
    dreq = 4'b0100;
    waitCyc(10);
    check("R6 irq raised", {28'b0, irq}, 32'h4);
    wr(2, 3'd4, 32'h0);
    check("R6 write of zero keeps flag", {28'b0, xferEnd}, 32'h4);
    wr(2, 3'd4, 32'h1);
    check("R6 irq cleared", {28'b0, irq}, 32'h0);
  endtask

  task automatic testCountZero();
    doReset();
    prog(0, 32'h0, 32'h9000, 32'd0, cfgWord(1, 0, 0, 1, 1, 1, 0, 0));
    dreq = 4'b0001;
    waitCyc(20);
    dreq = 4'b0000;
    waitCyc(3);
    check("R5 count zero keeps running", {31'b0, (nLog >= 8)}, 32'd1);
    check("R5 count zero no completion", {28'b0, xferEnd}, 32'h0);
    checkLog("R5 address keeps stepping", 7, 32'h9007, 1'b1, 4'b0001);
  endtask

  task automatic testArbitration();
    logic [3:0] expFix [4] = '{4'b0010, 4'b0010, 4'b0100, 4'b0100};
    logic [3:0] expRr  [4] = '{4'b0010, 4'b0100, 4'b0010, 4'b0100};
    doReset();
    prog(1, 32'h0, 32'h100, 32'd2, cfgWord(1, 0, 0, 1, 1, 1, 0, 0));
    prog(2, 32'h0, 32'h200, 32'd2, cfgWord(1, 0, 0, 1, 1, 1, 0, 0));
    dreq = 4'b0110;
    waitCyc(20);
    check("R7 fixed count", nLog, 4);
    for (int i = 0; i < 4; i++) check("R7 fixed priority order", {28'b0, logDack[i]}, {28'b0, expFix[i]});
    doReset();
    arbRoundRobin = 1'b1;
    prog(1, 32'h0, 32'h100, 32'd2, cfgWord(1, 0, 0, 1, 1, 1, 0, 0));
    prog(2, 32'h0, 32'h200, 32'd2, cfgWord(1, 0, 0, 1, 1, 1, 0, 0));
    dreq = 4'b0110;
    waitCyc(20);
    check("R8 rr count", nLog, 4);
    for (int i = 0; i < 4; i++) check("R8 round robin order", {28'b0, logDack[i]}, {28'b0, expRr[i]});
  endtask

  task automatic testBurst();
    logic [3:0] expSeq [4] = '{4'b1000, 4'b1000, 4'b1000, 4'b0001};
    doReset();
    prog(0, 32'h0, 32'h100, 32'd1, cfgWord(0, 0, 0, 1, 1, 1, 0, 0));
    prog(3, 32'h0, 32'h300, 32'd3, cfgWord(1, 0, 0, 1, 1, 1, 1, 0));
    dreq = 4'b1001;
    while (!busReq) @(negedge clk);
    wr(0, 3'd3, cfgWord(1, 0, 0, 1, 1, 1, 0, 0));
    waitCyc(15);
    check("R9 burst count", nLog, 4);
    for (int i = 0; i < 4; i++) check("R9 burst keeps bus", {28'b0, logDack[i]}, {28'b0, expSeq[i]});
  endtask

  task automatic testStall();
    doReset();
    busReady = 1'b0;
    prog(0, 32'h4000, 32'h6000, 32'd1, cfgWord(1, 2, 1, 1, 0, 0, 0, 0));
    dreq = 4'b0001;
    waitCyc(6);
    check("R10 request held", {31'b0, busReq}, 32'd1);
    check("R10 address held", busAddr, 32'h4000);
    check("R10 read held", {31'b0, busWrite}, 32'd0);
    check("R10 size held", {29'b0, busSize}, 32'd2);
    check("R10 no completion while stalled", {28'b0, xferEnd}, 32'h0);
    busReady = 1'b1;
    waitCyc(6);
    check("R10 resumes", nLog, 2);
    checkLog("R10 write after stall", 1, 32'h6000, 1'b1, 4'b0);
  endtask

  initial begin
    testReset();
    testDual();
    testSteps();
    testSingle();
    testCompletion();
    testCountZero();
    testArbitration();
    testBurst();
    testStall();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule